// File: doc/BRIEF.md
# Programmable pixel-phase edge generator

This block produces the fast timing waveforms for reading out a CCD sensor and for clocking a correlated double sampling front end. It runs on a fast clock and divides each pixel period into 48 phase slots with a phase counter. It compares that counter against programmed edge positions to generate a reset-gate pulse, four horizontal clocks and two sample strobes. Two of the horizontal clocks are always the complements of the other two. A divide-by-two mode stretches each phase slot over two fast clocks. This suits a timing reference that runs at twice the rate the slot grid expects.

Edge positions are six-bit codes. The upper two bits pick one quarter of the pixel period, at slot offset 0, 12, 24 or 36. The lower four bits pick a slot from 0 to 11 inside that quarter, and the values 12 to 15 are clamped to 11. Software writes codes and control bits through a simple write port into a staging copy. The staging copy is moved into the working copy only when a new pixel period starts, so a waveform never changes partway through a period. A pixel-sync input restarts the period at slot 0. The block also passes an inverted copy of the reference clock input to a crystal-driver pin.

Top module: `pix_edge_gen`

## Requirements
- R1: The phase counter steps through slots 0 to 47 and then returns to 0. A high `pix_sync` at a clock edge forces slot 0 at that edge and starts a new period.
- R2: An edge code maps to slot (code[5:4] × 12) + min(code[3:0], 11). For example, codes 0x0F and 0x0B both select slot 11.
- R3: When the rise slot is less than the fall slot, a windowed output (before polarity) is high for phase slots in [rise, fall).
- R4: When the fall slot is less than the rise slot, the window is high from the rise slot, across the wrap, up to the fall slot (slot ≥ rise or slot < fall).
- R5: When the rise and fall slots are equal, the window is always low before polarity is applied.
- R6: Control bit 0 inverts `rg`, bit 1 inverts `h1`, and bit 2 inverts `h3`. Each bit acts independently of the others.
- R7: `h2` is always the inverse of `h1`, and `h4` is always the inverse of `h3`.
- R8: `shp` and `shd` are each high for exactly one phase slot per period, at their own programmed slot.
- R9: A write goes to a staging copy only. It takes effect when the next period starts (at a wrap or a sync). A write made in the same cycle as that period start waits for the period after it.
- R10: Control bit 3 selects divide-by-two mode. In this mode each slot lasts two clocks and a period lasts 96 clocks. Without it a period lasts 48 clocks.
- R11: `ref_out` is the combinational inverse of `ref_in`.
- R12: While reset is held, `rg`, `h1`, `h3`, `shp` and `shd` are 0 and `h2` and `h4` are 1. All codes and control bits reset to 0.
- R13: Output latency is one clock: each waveform output shows the value for the phase slot and working settings held before the last clock edge. Register addresses are: 0 rg rise, 1 rg fall, 2 h1 rise, 3 h1 fall, 4 h3 rise, 5 h3 fall, 6 shp, 7 shd, 8 control. Writes to addresses 9 to 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast slot clock |
| rst | input | 1 | Asynchronous reset, active high |
| pix_sync | input | 1 | Restarts the pixel period at slot 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0–8 valid) |
| wr_data | input | 6 | Edge code or control bits |
| ref_in | input | 1 | Reference clock input |
| ref_out | output | 1 | Inverted reference clock |
| rg | output | 1 | Reset-gate pulse |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Inverse of h1 |
| h3 | output | 1 | Horizontal clock 3 |
| h4 | output | 1 | Inverse of h3 |
| shp | output | 1 | Reset-level sample strobe |
| shd | output | 1 | Data-level sample strobe |

## Verification
The hardest case to reach from the ports is a write that lands in the same clock edge as a period start, because it must skip a whole period. The bench tracks its own phase model and waits until that model reports slot 47. It then issues the write so that it meets the wrap edge. It repeats this with a `pix_sync` pulse issued mid-period. The divide-by-two switch is also made to take effect at a wrap. This checks that the slot stretching starts cleanly on a period boundary.

// File: rtl/pe_pkg.sv
package pe_pkg;

   // register indices of the write port
   typedef enum logic [3:0] {
      PE_RG_RISE = 4'd0,
      PE_RG_FALL = 4'd1,
      PE_H1_RISE = 4'd2,
      PE_H1_FALL = 4'd3,
      PE_H3_RISE = 4'd4,
      PE_H3_FALL = 4'd5,
      PE_SHP_LOC = 4'd6,
      PE_SHD_LOC = 4'd7,
      PE_CTRL    = 4'd8
   } pe_reg_e;

   localparam int PE_NUM_CODES = 8;
   localparam int PE_CTRL_W    = 4;

   // control bit positions
   localparam int PE_B_RG_INV = 0;
   localparam int PE_B_H1_INV = 1;
   localparam int PE_B_H3_INV = 2;
   localparam int PE_B_DIV2   = 3;

endpackage

// File: rtl/pe_phase_counter.sv
module pe_phase_counter #(
   parameter int PERIOD = 48,
   parameter int PH_W   = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pix_sync,
   input  logic            div2,
   output logic [PH_W-1:0] phase,
   output logic            advance,
   output logic            reload
);
   localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

   logic half_q;

   assign advance = ~div2 | half_q;
   assign reload  = pix_sync | (advance & (phase == LAST));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase  <= '0;
         half_q <= 1'b0;
      end else if (pix_sync) begin
         phase  <= '0;
         half_q <= 1'b0;
      end else begin
         if (advance) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
         end
         half_q <= div2 ? ~half_q : 1'b0;
      end
   end
endmodule

// File: rtl/pe_edge_bank.sv
module pe_edge_bank
   import pe_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int ADDR_W = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [CODE_W-1:0]              wr_data,
   input  logic                           reload,
   output logic [PE_NUM_CODES*CODE_W-1:0] act_codes,
   output logic [PE_CTRL_W-1:0]           act_ctrl
);
   logic [PE_NUM_CODES*CODE_W-1:0] stg_codes;
   logic [PE_CTRL_W-1:0]           stg_ctrl;

   for (genvar i = 0; i < PE_NUM_CODES; i++) begin : g_code
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            stg_codes[i*CODE_W +: CODE_W] <= '0;
            act_codes[i*CODE_W +: CODE_W] <= '0;
         end else begin
            if (reload) begin
               act_codes[i*CODE_W +: CODE_W] <= stg_codes[i*CODE_W +: CODE_W];
            end
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
               stg_codes[i*CODE_W +: CODE_W] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         stg_ctrl <= '0;
         act_ctrl <= '0;
      end else begin
         if (reload) begin
            act_ctrl <= stg_ctrl;
         end
         if (wr_en && (wr_addr == ADDR_W'(PE_CTRL))) begin
            stg_ctrl <= wr_data[PE_CTRL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pe_code_map.sv
module pe_code_map #(
   parameter int QUAD_BITS  = 2,
   parameter int SLOT_BITS  = 4,
   parameter int QUAD_SLOTS = 12,
   parameter int PH_W       = 6
) (
   input  logic [QUAD_BITS+SLOT_BITS-1:0] code,
   output logic [PH_W-1:0]                slot
);
   localparam int CODE_W = QUAD_BITS + SLOT_BITS;

   logic [QUAD_BITS-1:0] quad;
   logic [SLOT_BITS-1:0] low;
   int                   low_c;

   assign quad = code[CODE_W-1 -: QUAD_BITS];
   assign low  = code[SLOT_BITS-1:0];

   always_comb begin
      low_c = (int'(low) > QUAD_SLOTS - 1) ? QUAD_SLOTS - 1 : int'(low);
      slot  = PH_W'(int'(quad) * QUAD_SLOTS + low_c);
   end
endmodule

// File: rtl/pe_wave.sv
module pe_wave #(
   parameter int PH_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rst_val,
   input  logic [PH_W-1:0] phase,
   input  logic [PH_W-1:0] rise,
   input  logic [PH_W-1:0] fall,
   input  logic            inv,
   output logic            wave
);
   logic hit;

   always_comb begin
      if (rise < fall)      hit = (phase >= rise) && (phase < fall);
      else if (rise > fall) hit = (phase >= rise) || (phase < fall);
      else                  hit = 1'b0;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) wave <= rst_val;
      else     wave <= hit ^ inv;
   end
endmodule

// File: rtl/pix_edge_gen.sv
module pix_edge_gen
   import pe_pkg::*;
#(
   parameter int QUAD_BITS  = 2,
   parameter int SLOT_BITS  = 4,
   parameter int QUAD_SLOTS = 12,
   parameter int ADDR_W     = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           pix_sync,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [QUAD_BITS+SLOT_BITS-1:0] wr_data,
   input  logic                           ref_in,
   output logic                           ref_out,
   output logic                           rg,
   output logic                           h1,
   output logic                           h2,
   output logic                           h3,
   output logic                           h4,
   output logic                           shp,
   output logic                           shd
);
   localparam int CODE_W = QUAD_BITS + SLOT_BITS;
   localparam int PERIOD = QUAD_SLOTS * (1 << QUAD_BITS);
   localparam int PH_W   = $clog2(PERIOD);
   localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

   if (QUAD_SLOTS > (1 << SLOT_BITS)) begin : g_bad_slots
      $error("QUAD_SLOTS does not fit in SLOT_BITS");
   end
   if (CODE_W < PE_CTRL_W) begin : g_bad_code
      $error("edge code narrower than control field");
   end
   if ((1 << ADDR_W) <= int'(PE_CTRL)) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   logic [PH_W-1:0]                phase;
   logic                           advance;
   logic                           reload;
   logic [PE_NUM_CODES*CODE_W-1:0] act_codes;
   logic [PE_CTRL_W-1:0]           act_ctrl;
   logic [PH_W-1:0]                slot_w [PE_NUM_CODES];
   logic [PH_W-1:0]                rg_r_slot, rg_f_slot;
   logic [PH_W-1:0]                shp_end, shd_end;

   assign ref_out = ~ref_in;

   pe_phase_counter #(.PERIOD(PERIOD), .PH_W(PH_W)) u_ctr (
      .clk(clk), .rst(rst), .pix_sync(pix_sync),
      .div2(act_ctrl[PE_B_DIV2]),
      .phase(phase), .advance(advance), .reload(reload)
   );

   pe_edge_bank #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .reload(reload),
      .act_codes(act_codes), .act_ctrl(act_ctrl)
   );

   for (genvar i = 0; i < PE_NUM_CODES; i++) begin : g_map
      pe_code_map #(
         .QUAD_BITS(QUAD_BITS), .SLOT_BITS(SLOT_BITS),
         .QUAD_SLOTS(QUAD_SLOTS), .PH_W(PH_W)
      ) u_map (
         .code(act_codes[i*CODE_W +: CODE_W]),
         .slot(slot_w[i])
      );
   end

   assign rg_r_slot = slot_w[PE_RG_RISE];
   assign rg_f_slot = slot_w[PE_RG_FALL];
   // a strobe is a one-slot window ending at the following slot
   assign shp_end = (slot_w[PE_SHP_LOC] == LAST) ? '0 : slot_w[PE_SHP_LOC] + 1'b1;
   assign shd_end = (slot_w[PE_SHD_LOC] == LAST) ? '0 : slot_w[PE_SHD_LOC] + 1'b1;

   pe_wave #(.PH_W(PH_W)) u_rg (
      .clk(clk), .rst(rst), .rst_val(1'b0), .phase(phase),
      .rise(rg_r_slot), .fall(rg_f_slot),
      .inv(act_ctrl[PE_B_RG_INV]), .wave(rg)
   );
   pe_wave #(.PH_W(PH_W)) u_h1 (
      .clk(clk), .rst(rst), .rst_val(1'b0), .phase(phase),
      .rise(slot_w[PE_H1_RISE]), .fall(slot_w[PE_H1_FALL]),
      .inv(act_ctrl[PE_B_H1_INV]), .wave(h1)
   );
   pe_wave #(.PH_W(PH_W)) u_h2 (
      .clk(clk), .rst(rst), .rst_val(1'b1), .phase(phase),
      .rise(slot_w[PE_H1_RISE]), .fall(slot_w[PE_H1_FALL]),
      .inv(~act_ctrl[PE_B_H1_INV]), .wave(h2)
   );
   pe_wave #(.PH_W(PH_W)) u_h3 (
      .clk(clk), .rst(rst), .rst_val(1'b0), .phase(phase),
      .rise(slot_w[PE_H3_RISE]), .fall(slot_w[PE_H3_FALL]),
      .inv(act_ctrl[PE_B_H3_INV]), .wave(h3)
   );
   pe_wave #(.PH_W(PH_W)) u_h4 (
      .clk(clk), .rst(rst), .rst_val(1'b1), .phase(phase),
      .rise(slot_w[PE_H3_RISE]), .fall(slot_w[PE_H3_FALL]),
      .inv(~act_ctrl[PE_B_H3_INV]), .wave(h4)
   );
   pe_wave #(.PH_W(PH_W)) u_shp (
      .clk(clk), .rst(rst), .rst_val(1'b0), .phase(phase),
      .rise(slot_w[PE_SHP_LOC]), .fall(shp_end),
      .inv(1'b0), .wave(shp)
   );
   pe_wave #(.PH_W(PH_W)) u_shd (
      .clk(clk), .rst(rst), .rst_val(1'b0), .phase(phase),
      .rise(slot_w[PE_SHD_LOC]), .fall(shd_end),
      .inv(1'b0), .wave(shd)
   );
endmodule

// File: rtl/pix_edge_gen_chk.sv
module pix_edge_gen_chk #(
   parameter int PH_W   = 6,
   parameter int PERIOD = 48,
   parameter int CW     = 48
) (
   input logic            clk,
   input logic            rst,
   input logic            pix_sync,
   input logic [PH_W-1:0] phase,
   input logic            advance,
   input logic            reload,
   input logic [CW-1:0]   act_codes,
   input logic [3:0]      act_ctrl,
   input logic [PH_W-1:0] rg_r_slot,
   input logic [PH_W-1:0] rg_f_slot,
   input logic            rg,
   input logic            h1,
   input logic            h2,
   input logic            h3,
   input logic            h4
);
   // R1
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      int'(phase) < PERIOD);

   // R1
   phase_sync_chk: assert property (@(posedge clk) disable iff (rst)
      pix_sync |=> (phase == '0));

   // R10
   phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pix_sync && !advance) |=> $stable(phase));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !reload |=> ($stable(act_codes) && $stable(act_ctrl)));

   // R7
   h_comp_chk: assert property (@(posedge clk) disable iff (rst)
      (h2 == ~h1) && (h4 == ~h3));

   // R5
   rg_equal_chk: assert property (@(posedge clk) disable iff (rst)
      (rg_r_slot == rg_f_slot) |=> (rg == $past(act_ctrl[0])));
endmodule

bind pix_edge_gen pix_edge_gen_chk #(
   .PH_W(PH_W), .PERIOD(PERIOD), .CW(pe_pkg::PE_NUM_CODES * CODE_W)
) u_chk (
   .clk(clk), .rst(rst), .pix_sync(pix_sync), .phase(phase),
   .advance(advance), .reload(reload), .act_codes(act_codes),
   .act_ctrl(act_ctrl), .rg_r_slot(rg_r_slot), .rg_f_slot(rg_f_slot),
   .rg(rg), .h1(h1), .h2(h2), .h3(h3), .h4(h4)
);

// File: tb/test_pix_edge_gen.sv
`timescale 1ns/1ps
module test_pix_edge_gen;
   logic       clk = 1'b0, rst = 1'b1, pix_sync = 1'b0, wr_en = 1'b0, ref_in = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [5:0] wr_data = '0;
   logic       ref_out, rg, h1, h2, h3, h4, shp, shd;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pix_edge_gen i_pix_edge_gen (
      .clk(clk), .rst(rst), .pix_sync(pix_sync), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ref_in(ref_in),
      .ref_out(ref_out), .rg(rg), .h1(h1), .h2(h2), .h3(h3), .h4(h4),
      .shp(shp), .shd(shd)
   );

   // ---------------- behavioural reference ----------------
   int         m_ph, m_half;
   logic [5:0] m_stg [9];
   logic [5:0] m_act [9];
   logic       e_rg, e_h1, e_h2, e_h3, e_h4, e_shp, e_shd;

   function automatic int slot_of(logic [5:0] c);
      int lo = int'(c[3:0]);
      if (lo > 11) lo = 11;
      return int'(c[5:4]) * 12 + lo;
   endfunction

   function automatic logic win(int p, int r, int f);
      if (r == f) return 1'b0;
      if (r < f)  return (p >= r) && (p < f);
      return (p >= r) || (p < f);
   endfunction

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_ph = 0; m_half = 0;
         for (int i = 0; i < 9; i++) begin m_stg[i] = '0; m_act[i] = '0; end
         e_rg = 0; e_h1 = 0; e_h2 = 1; e_h3 = 0; e_h4 = 1; e_shp = 0; e_shd = 0;
      end else begin
         bit adv, rel, div;
         cyc++;
         e_rg  = win(m_ph, slot_of(m_act[0]), slot_of(m_act[1])) ^ m_act[8][0];
         e_h1  = win(m_ph, slot_of(m_act[2]), slot_of(m_act[3])) ^ m_act[8][1];
         e_h2  = !e_h1;
         e_h3  = win(m_ph, slot_of(m_act[4]), slot_of(m_act[5])) ^ m_act[8][2];
         e_h4  = !e_h3;
         e_shp = (m_ph == slot_of(m_act[6]));
         e_shd = (m_ph == slot_of(m_act[7]));
         div = m_act[8][3];
         adv = !div || (m_half == 1);
         rel = 0;
         if (pix_sync) begin
            m_ph = 0; m_half = 0; rel = 1;
         end else begin
            if (adv) begin
               if (m_ph == 47) begin m_ph = 0; rel = 1; end
               else m_ph++;
            end
            m_half = div ? 1 - m_half : 0;
         end
         if (rel) for (int i = 0; i < 9; i++) m_act[i] = m_stg[i];
         if (wr_en && wr_addr < 9) m_stg[wr_addr] = wr_data;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // R13 one-clock latency checked on every cycle against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(rg == e_rg, "R3/R4/R5/R6/R13 rg", rg, e_rg);
         chk(h1 == e_h1, "R3/R4/R6/R9/R13 h1", h1, e_h1);
         chk(h3 == e_h3, "R3/R5/R6/R13 h3", h3, e_h3);
         chk(h2 == e_h2 && h4 == e_h4, "R7 h2/h4", {h2, h4}, {e_h2, e_h4});
         chk(shp == e_shp && shd == e_shd, "R8 shp/shd", {shp, shd}, {e_shp, e_shd});
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 6'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ph(int p);
      while (m_ph != p) @(negedge clk);
   endtask

   task automatic shp_period(output int len);
      int start;
      logic prev;
      prev = shp; @(negedge clk);
      while (!(shp && !prev)) begin prev = shp; @(negedge clk); end
      start = cyc;
      prev = shp; @(negedge clk);
      while (!(shp && !prev)) begin prev = shp; @(negedge clk); end
      len = cyc - start;
   endtask

   initial begin
      int len;
      // R12 reset state
      repeat (3) @(negedge clk);
      chk(rg == 0 && h1 == 0 && h3 == 0 && shp == 0 && shd == 0, "R12 reset low outs",
          {rg, h1, h3, shp, shd}, 0);
      chk(h2 == 1 && h4 == 1, "R12 reset high outs", {h2, h4}, 3);
      rst = 1'b0;
      @(negedge clk);

      // R11 reference inverter
      ref_in = 1'b1; #1 chk(ref_out == 1'b0, "R11 ref high", ref_out, 0);
      ref_in = 1'b0; #1 chk(ref_out == 1'b1, "R11 ref low", ref_out, 1);
      @(negedge clk);

      // R3 plain windows, R2 quadrant mapping, R8 strobes
      wr(0, 6'h03); wr(1, 6'h14); wr(2, 6'h00); wr(3, 6'h20);
      wr(4, 6'h10); wr(5, 6'h30); wr(6, 6'h25); wr(7, 6'h35);
      repeat (150) @(negedge clk);

      // R1 period length in normal mode
      shp_period(len);
      chk(len == 48, "R1 normal period", len, 48);

      // R4 wrap-around window
      wr(0, 6'h32); wr(1, 6'h05);
      repeat (100) @(negedge clk);

      // R5 equal rise and fall, then R6 polarity per output
      wr(4, 6'h12); wr(5, 6'h12);
      repeat (100) @(negedge clk);
      wr(8, 6'h04);
      repeat (100) @(negedge clk);
      wr(8, 6'h03);
      repeat (100) @(negedge clk);
      wr(8, 6'h00);

      // R2 clamp: low field 15 and 11 select the same slot
      wr(6, 6'h0F); wr(7, 6'h0B);
      repeat (100) @(negedge clk);
      for (int i = 0; i < 60; i++) begin
         chk(shp == shd, "R2 clamp shp vs shd", shp, shd);
         @(negedge clk);
      end
      wr(6, 6'h1C); wr(7, 6'h1B);
      repeat (100) @(negedge clk);
      chk(slot_of(6'h1C) == 23, "R2 model slot of 0x1C", slot_of(6'h1C), 23);

      // R9 write at wrap edge waits one more period; mid-period write
      wait_ph(47);
      wr(3, 6'h2A);
      repeat (30) @(negedge clk);
      wait_ph(20);
      wr(2, 6'h06);
      repeat (150) @(negedge clk);

      // R1 sync mid-period, also with a pending write
      wait_ph(30);
      wr(0, 6'h01);
      pix_sync = 1'b1; @(negedge clk); pix_sync = 1'b0;
      repeat (20) @(negedge clk);
      pix_sync = 1'b1; @(negedge clk); pix_sync = 1'b0;
      repeat (100) @(negedge clk);

      // R10 divide-by-two mode, armed at a wrap
      wr(6, 6'h25);
      wait_ph(47);
      wr(8, 6'h08);
      repeat (250) @(negedge clk);
      shp_period(len);
      chk(len == 96, "R10 div2 period", len, 96);
      pix_sync = 1'b1; @(negedge clk); pix_sync = 1'b0;
      repeat (50) @(negedge clk);
      wr(8, 6'h00);
      repeat (250) @(negedge clk);
      shp_period(len);
      chk(len == 48, "R10 back to normal period", len, 48);

      // R13 out-of-range address is ignored
      wr(9, 6'h3F); wr(15, 6'h3F);
      repeat (150) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule